// File: doc/BRIEF.md
# Multi-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that runs six instructions: add, sub, load word, store word, branch-if-equal and jump. Each instruction takes several clock cycles. A state machine moves it through the stages it needs: fetch, register read, ALU, memory or register write, and load write-back. Values that cross a stage boundary are held in internal registers: the instruction word, the two operands, the ALU result and the loaded data.

The core has one memory port, which it uses for both instructions and data. Fetches and data accesses therefore fall in different cycles. The memory lives outside the core. The core drives a byte address, write data and a write strobe, and expects combinational read data from the word at that address. A single ALU performs the PC increment, the branch-target addition, address arithmetic, the R-type operation and the branch compare, each in a different cycle. Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump target [25:0].

Top module: `mc_core`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, mem_addr_o is 0 and mem_we_o is 0. All general registers read 0 after reset.
- R2: A fetch cycle puts PC on mem_addr_o, latches the instruction and advances PC by 4. A data access happens in the fourth cycle of a load or store, at the computed address.
- R3: Instructions take a fixed number of cycles from one fetch to the next: lw takes 5, R-type and sw take 4, and beq and j take 3.
- R4: Opcode 000000 with funct 100000 writes rs+rt to rd. Opcode 000000 with funct 100010 writes rs-rt to rd, with 32-bit wrap.
- R5: lw (opcode 100011) loads rt from memory at rs plus the sign-extended immediate. sw (opcode 101011) stores rt there. Negative offsets work.
- R6: beq (opcode 000100) sets PC to PC+4 plus the sign-extended immediate times 4 when rs equals rt. Otherwise execution falls through. The offset may be negative.
- R7: j (opcode 000010) sets PC to the top four bits of PC+4, followed by the 26-bit target field, followed by 00.
- R8: Register 0 reads as zero, and both loads and R-type writes to it are discarded.
- R9: Any other opcode, or opcode 000000 with any other funct, returns to fetch after two cycles. It writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address of the shared memory port |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data of the addressed word |
| mem_we_o | output | 1 | Write strobe for a store |

## Verification
In the register-read cycle, the ALU computes the branch target from PC while the register file supplies both compare operands. In the next cycle the compare decides whether that early sum becomes PC. Branches are exercised with equal and unequal operands and with forward and backward offsets, including a loop that exits on a count. The bench judges the result by the stores that run or are skipped, and by the cycle in which each fetch address appears on the port.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB
  } state_e;

  typedef enum logic [2:0] {
    K_RTYPE, K_LW, K_SW, K_BEQ, K_J, K_BAD
  } kind_e;

  typedef enum logic {ALU_ADD, ALU_SUB} alu_op_e;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W      = 32,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] rf [NREGS];

  assign rf[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && waddr_i == AW'(i))    q <= wdata_i;
    end
    assign rf[i] = q;
  end

  assign rdata_a_o = rf[raddr_a_i];
  assign rdata_b_o = rf[raddr_b_i];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output state_e     state_o,
  output kind_e      kind_o,
  output alu_op_e    rtype_op_o
);
  state_e state_q, state_d;

  always_comb begin
    kind_o     = K_BAD;
    rtype_op_o = ALU_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        if (funct_i == FN_ADD) kind_o = K_RTYPE;
        if (funct_i == FN_SUB) begin
          kind_o     = K_RTYPE;
          rtype_op_o = ALU_SUB;
        end
      end
      OP_LW:   kind_o = K_LW;
      OP_SW:   kind_o = K_SW;
      OP_BEQ:  kind_o = K_BEQ;
      OP_J:    kind_o = K_J;
      default: kind_o = K_BAD;
    endcase
  end

  always_comb begin
    state_d = S_FETCH;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: state_d = (kind_o == K_BAD) ? S_FETCH : S_EXEC;
      S_EXEC:   state_d = (kind_o == K_BEQ || kind_o == K_J) ? S_FETCH : S_MEM;
      S_MEM:    state_d = (kind_o == K_LW) ? S_WB : S_FETCH;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  localparam int unsigned RAW  = $clog2(NREGS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        mem_we_o
);
  state_e  state;
  kind_e   kind;
  alu_op_e rtype_op;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
  logic [XLEN-1:0] imm_sx, rd_a, rd_b;
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  alu_op_e         alu_op;
  logic            alu_zero;
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  mc_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (ir_q[31:26]),
    .funct_i    (ir_q[5:0]),
    .state_o    (state),
    .kind_o     (kind),
    .rtype_op_o (rtype_op)
  );

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

  // one ALU, operands chosen by stage
  always_comb begin
    alu_a  = pc_q;
    alu_b  = XLEN'(4);
    alu_op = ALU_ADD;
    unique case (state)
      S_DECODE: alu_b = {imm_sx[XLEN-3:0], 2'b00};
      S_EXEC: begin
        alu_a = a_q;
        unique case (kind)
          K_RTYPE: begin alu_b = b_q; alu_op = rtype_op; end
          K_BEQ:   begin alu_b = b_q; alu_op = ALU_SUB;  end
          default: alu_b = imm_sx;
        endcase
      end
      default: ;
    endcase
  end

  mc_alu #(.W(XLEN)) i_alu (
    .op_i   (alu_op),
    .a_i    (alu_a),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  mc_regfile #(.W(XLEN), .NREGS(NREGS)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ir_q[21+RAW-1:21]),
    .raddr_b_i (ir_q[16+RAW-1:16]),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata)
  );

  assign rf_we    = (state == S_MEM && kind == K_RTYPE) || (state == S_WB);
  assign rf_waddr = (state == S_WB) ? ir_q[16+RAW-1:16] : ir_q[11+RAW-1:11];
  assign rf_wdata = (state == S_WB) ? mdr_q : alu_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
      mdr_q     <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          ir_q <= mem_rdata_i;
          pc_q <= alu_y;
        end
        S_DECODE: begin
          a_q       <= rd_a;
          b_q       <= rd_b;
          alu_out_q <= alu_y;  // early branch target
        end
        S_EXEC: begin
          if (kind == K_BEQ && alu_zero) pc_q <= alu_out_q;
          if (kind == K_J)               pc_q <= {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
          if (kind == K_RTYPE || kind == K_LW || kind == K_SW) alu_out_q <= alu_y;
        end
        S_MEM: if (kind == K_LW) mdr_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = (state == S_MEM) ? alu_out_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_we_o    = (state == S_MEM) && (kind == K_SW);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] mem_addr_i,
  input logic        mem_we_i,
  input state_e      state_i,
  input kind_e       kind_i,
  input logic [31:0] pc_i,
  input logic [31:0] ir_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [31:0] alu_out_i
);
  // R2
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |-> mem_addr_i == pc_i);

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |=> pc_i == $past(pc_i) + 32'd4);

  // R3
  fetch_to_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |=> state_i == S_DECODE);

  // R5
  store_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (state_i == S_MEM && mem_addr_i == alu_out_i));

  // R6
  beq_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_EXEC && kind_i == K_BEQ && a_i == b_i) |=> pc_i == $past(alu_out_i));

  // R8
  zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DECODE && ir_i[25:21] == 5'd0) |=> a_i == 32'd0);

  // R9
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DECODE && kind_i == K_BAD) |=> (state_i == S_FETCH && pc_i == $past(pc_i)));
endmodule

bind mc_core mc_core_chk i_mc_core_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .state_i    (state),
  .kind_i     (kind),
  .pc_i       (pc_q),
  .ir_i       (ir_q),
  .a_i        (a_q),
  .b_i        (b_q),
  .alu_out_i  (alu_out_q)
);

// File: tb/test_mc_core.sv
module test_mc_core;
  localparam logic [5:0] T_LW = 6'b100011, T_SW = 6'b101011, T_BEQ = 6'b000100;
  localparam logic [5:0] T_ADD = 6'b100000, T_SUB = 6'b100010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [256];
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [7:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < 256; i++) mem[i] <= '0;
    else if (ld_en) mem[ld_idx] <= ld_data;
    else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[9:2]];

  mc_core i_mc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, ptr = 0;
  logic [31:0] tr_addr [128];
  logic        tr_we   [128];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int byte_addr);
    return {6'b000010, 26'(byte_addr >> 2)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup();
    rst_ni = 1'b0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    ptr = 0;
  endtask
  task automatic poke(int addr, logic [31:0] d);
    ld_en = 1'b1; ld_idx = 8'(addr >> 2); ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask
  task automatic emit(logic [31:0] w);
    poke(ptr, w); ptr += 4;
  endtask
  task automatic run(int n);
    rst_ni = 1'b1;
    for (int c = 1; c <= n; c++) begin
      #1; tr_addr[c] = mem_addr; tr_we[c] = mem_we;
      @(negedge clk);
    end
  endtask
  function automatic logic [31:0] rd(int addr);
    return mem[addr >> 2];
  endfunction

  task automatic t_reset();
    setup();
    #1;
    check("R1 addr in reset", mem_addr, 32'h0);
    check("R1 we in reset", 32'(mem_we), 32'h0);
    run(1);
    check("R1 first fetch addr", tr_addr[1], 32'h0);
    check("R1 first fetch we", 32'(tr_we[1]), 32'h0);
  endtask

  task automatic t_timing();
    setup();
    poke(32'h100, 32'd7); poke(32'h104, 32'd12);
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_i(T_LW, 0, 2, 32'h104));
    emit(enc_r(1, 2, 3, T_ADD));
    emit(enc_r(1, 2, 4, T_SUB));
    emit(enc_i(T_SW, 0, 3, 32'h108));
    emit(enc_i(T_SW, 0, 4, 32'h10C));
    emit(enc_i(T_BEQ, 0, 0, 0));
    emit(enc_j(32));
    emit(enc_j(32));
    run(40);
    check("R2 load data access cycle 4", tr_addr[4], 32'h100);
    check("R3 lw 5 cycles", tr_addr[6], 32'd4);
    check("R3 R-type 4 cycles", tr_addr[15], 32'd12);
    check("R3 sw 4 cycles", tr_addr[23], 32'd20);
    check("R3 beq 3 cycles", tr_addr[30], 32'd28);
    check("R3 j 3 cycles", tr_addr[33], 32'd32);
    check("R2 store strobe cycle", 32'(tr_we[22]), 32'd1);
    check("R2 store address", tr_addr[22], 32'h108);
    check("R4 add", rd(32'h108), 32'd19);
    check("R4 sub wraps", rd(32'h10C), 32'hFFFF_FFFB);
  endtask

  task automatic t_neg_offset();
    setup();
    poke(32'h100, 32'h140); poke(32'h13C, 32'hCAFE_0001);
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_i(T_LW, 1, 2, -4));
    emit(enc_i(T_SW, 1, 2, -8));
    emit(enc_j(12));
    run(30);
    check("R5 negative offsets", rd(32'h138), 32'hCAFE_0001);
  endtask

  task automatic t_reg0();
    setup();
    poke(32'h100, 32'h55); poke(32'h104, 32'hFFFF); poke(32'h108, 32'hAAAA);
    emit(enc_i(T_LW, 0, 0, 32'h100));
    emit(enc_i(T_SW, 0, 0, 32'h104));
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_r(1, 1, 0, T_ADD));
    emit(enc_i(T_SW, 0, 0, 32'h108));
    emit(enc_j(20));
    run(40);
    check("R8 load to r0 discarded", rd(32'h104), 32'h0);
    check("R8 add to r0 discarded", rd(32'h108), 32'h0);
  endtask

  task automatic t_beq();
    setup();
    poke(32'h100, 32'd5); poke(32'h104, 32'd5); poke(32'h108, 32'd9);
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_i(T_LW, 0, 2, 32'h104));
    emit(enc_i(T_LW, 0, 3, 32'h108));
    emit(enc_i(T_BEQ, 1, 2, 1));
    emit(enc_i(T_SW, 0, 1, 32'h10C));
    emit(enc_i(T_BEQ, 1, 3, 5));
    emit(enc_i(T_SW, 0, 3, 32'h110));
    emit(enc_j(28));
    run(60);
    check("R6 taken skips store", rd(32'h10C), 32'h0);
    check("R6 not taken falls through", rd(32'h110), 32'd9);
  endtask

  task automatic t_loop();
    setup();
    poke(32'h100, 32'd1); poke(32'h104, 32'd3);
    emit(enc_i(T_LW, 0, 5, 32'h100));
    emit(enc_i(T_LW, 0, 6, 32'h104));
    emit(enc_r(7, 5, 7, T_ADD));
    emit(enc_i(T_BEQ, 7, 6, 1));
    emit(enc_i(T_BEQ, 0, 0, -3));
    emit(enc_i(T_SW, 0, 7, 32'h108));
    emit(enc_j(24));
    run(80);
    check("R6 backward loop count", rd(32'h108), 32'd3);
    check("R1 register starts at zero", rd(32'h108) - 32'd3, 32'h0);
  endtask

  task automatic t_jump();
    setup();
    poke(32'h100, 32'hBEEF); poke(32'h108, 32'h1111);
    emit(enc_j(12));
    emit(enc_i(T_SW, 0, 0, 32'h108));
    emit(enc_j(8));
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_i(T_SW, 0, 1, 32'h104));
    emit(enc_j(8));
    run(30);
    check("R7 jump target fetch", tr_addr[4], 32'd12);
    check("R7 jumped-over store skipped", rd(32'h108), 32'h1111);
    check("R7 code at target runs", rd(32'h104), 32'hBEEF);
  endtask

  task automatic t_bad();
    int wes;
    setup();
    poke(32'h100, 32'h77); poke(32'h108, 32'h2222);
    emit(enc_i(T_LW, 0, 1, 32'h100));
    emit(enc_i(6'b001000, 0, 1, 5));
    emit(enc_r(1, 1, 2, 6'b100101));
    emit(enc_i(T_SW, 0, 1, 32'h104));
    emit(enc_i(T_SW, 0, 2, 32'h108));
    emit(enc_j(20));
    run(40);
    wes = 0;
    for (int c = 6; c <= 9; c++) wes += int'(tr_we[c]);
    check("R9 unknown opcode two cycles", tr_addr[8], 32'd8);
    check("R9 unknown funct two cycles", tr_addr[10], 32'd12);
    check("R9 no memory write", 32'(wes), 32'h0);
    check("R9 rt untouched", rd(32'h104), 32'h77);
    check("R9 rd untouched", rd(32'h108), 32'h0);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_neg_offset();
    t_reg0();
    t_beq();
    t_loop();
    t_jump();
    t_bad();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule